// File: doc/BRIEF.md
# Integer Execute Stage

This block is the execute stage of a 32-bit integer pipeline. A decoder in front of it supplies the major opcode, the three-bit function code, the single function bit that separates subtraction from addition and arithmetic from logical right shifts, the destination register index, the two source register values, the instruction's PC and an immediate that the decoder has already sign-extended. From these the stage computes the value to write back, whether to write it, the address of the next instruction and the effective address for a memory access.

All arithmetic is combinational. A single register stage captures the results whenever the input valid is high and holds them otherwise. The loaded data, the store path, control registers and traps are handled elsewhere. The reset is asserted asynchronously and released through a short synchroniser, so the stage leaves reset a fixed number of clock edges after the reset pin rises.

Opcode values (bits 6:0): upper-immediate 0110111, PC-relative upper-immediate 0010111, direct jump 1101111, register jump 1100111, conditional branch 1100011, load 0000011, store 0100011, immediate ALU 0010011, register ALU 0110011.

Top module: `int_exec_unit`

## Requirements
- R1: While the reset is active, and until the first accepted instruction, out_valid, wb_en, wb_data, next_pc and mem_addr are all zero.
- R2: The results of an instruction presented with in_valid high appear on the outputs after the next rising clock edge, with out_valid high. In a cycle where in_valid is low, out_valid drops on the next edge and every other output keeps its value.
- R3: The upper-immediate opcode writes the immediate. The PC-relative upper-immediate opcode writes PC plus the immediate.
- R4: Both jumps write PC+4. The direct jump goes to PC plus the immediate. The register jump goes to rs1 plus the immediate with bit 0 forced to zero.
- R5: A conditional branch compares rs1 with rs2 according to funct3: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal. The codes 010 and 011 are never taken. A taken branch goes to PC plus the immediate.
- R6: Branches, loads, stores and unknown opcodes leave wb_en low. For a load or a store, mem_addr is rs1 plus the immediate.
- R7: The register ALU funct3 codes are 000 add (sub when funct7_b5 is 1), 100 xor, 110 or and 111 and. In the immediate ALU the same codes use the immediate as the second operand, and funct7_b5 never turns an add into a subtract.
- R8: The shift codes are 001 left and 101 right. A right shift is arithmetic when funct7_b5 is 1 and logical otherwise. The shift amount is the low 5 bits of rs2, or of the immediate for the immediate ALU. An arithmetic shift fills with the sign bit.
- R9: Codes 010 (signed) and 011 (unsigned) write 1 if the first operand is below the second and 0 otherwise. For the immediate form, 011 treats the sign-extended immediate as an unsigned number.
- R10: An instruction whose destination index is 0 never raises wb_en, so register 0 stays zero.
- R11: Every instruction that is not a jump and not a taken branch sets next_pc to PC+4. This includes unknown opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | The decoded instruction on the inputs is valid |
| opcode | input | 7 | Major opcode |
| funct3 | input | 3 | Function code |
| funct7_b5 | input | 1 | Sub / arithmetic-shift select bit |
| rd_idx | input | 5 | Destination register index |
| rs1_val | input | XLEN | First source operand |
| rs2_val | input | XLEN | Second source operand |
| pc | input | XLEN | Address of the instruction |
| imm | input | XLEN | Sign-extended immediate |
| out_valid | output | 1 | The registered results belong to an instruction accepted on the previous edge |
| wb_en | output | 1 | Write wb_data into register wb_idx |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | XLEN | Write-back value |
| next_pc | output | XLEN | Address of the next instruction |
| mem_addr | output | XLEN | Effective memory address |

## Verification
The bench builds the stage with its defaults: a 32-bit datapath and a two-stage reset synchroniser. At this width the sign bit sits at bit 31, so operands such as 0x80000000 and 0xFFFFFFFF exercise the boundaries of the signed and unsigned comparisons, the sign fill of arithmetic shifts and the wrap of additions. The five-bit shift-amount field is also checked to discard the upper bits of rs2. With two synchroniser stages, the bench sees the delay between releasing the reset pin and the first accepted instruction, and it also asserts the reset mid-run to check that the outputs clear at once.

// File: rtl/exu_pkg.sv
package exu_pkg;

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    PC_SEQ, PC_REL, PC_REG
  } pc_sel_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_LINK
  } wb_sel_e;

endpackage

// File: rtl/exu_rst_sync.sv
module exu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e           op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   y
);
  localparam int SHW = $clog2(XLEN);

  logic [SHW-1:0]  shamt;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] sra_res;

  assign shamt   = b[SHW-1:0];
  assign lt_s    = $signed(a) < $signed(b);
  assign lt_u    = a < b;
  assign sra_res = $unsigned($signed(a) >>> shamt);

  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_SLL:   y = a << shamt;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU:  y = {{(XLEN-1){1'b0}}, lt_u};
      ALU_XOR:   y = a ^ b;
      ALU_SRL:   y = a >> shamt;
      ALU_SRA:   y = sra_res;
      ALU_OR:    y = a | b;
      ALU_AND:   y = a & b;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/exu_branch_cmp.sv
module exu_branch_cmp #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hit
);
  logic eq;
  logic lt_s;
  logic lt_u;

  assign eq   = (a == b);
  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;

  always_comb begin
    unique case (cond)
      3'b000:  hit = eq;
      3'b001:  hit = !eq;
      3'b100:  hit = lt_s;
      3'b101:  hit = !lt_s;
      3'b110:  hit = lt_u;
      3'b111:  hit = !lt_u;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/exu_pc_unit.sv
module exu_pc_unit
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  pc_sel_e         sel,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] link,
  output logic [XLEN-1:0] eff_addr,
  output logic [XLEN-1:0] target
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] rel;

  assign link     = pc + STEP;
  assign rel      = pc + imm;
  assign eff_addr = base + imm;

  always_comb begin
    unique case (sel)
      PC_REL:  target = rel;
      PC_REG:  target = {eff_addr[XLEN-1:1], 1'b0};
      default: target = link;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [6:0]      opcode,
  input  logic [2:0]      funct3,
  input  logic            funct7_b5,
  input  logic [4:0]      rd_idx,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] imm,
  output logic            out_valid,
  output logic            wb_en,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] mem_addr
);

  logic core_rst_n;

  exu_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  // ---------------- decode of the operation ----------------
  alu_op_e         alu_op;
  pc_sel_e         pc_sel;
  wb_sel_e         wb_sel;
  logic [XLEN-1:0] alu_a;
  logic [XLEN-1:0] alu_b;
  logic            writes_rd;
  logic            is_branch;
  alu_op_e         f3_op;

  // funct3 to ALU operation; sub/sra only where the bit is meaningful
  always_comb begin
    unique case (funct3)
      3'b000:  f3_op = (opcode == OPC_OP && funct7_b5) ? ALU_SUB : ALU_ADD;
      3'b001:  f3_op = ALU_SLL;
      3'b010:  f3_op = ALU_SLT;
      3'b011:  f3_op = ALU_SLTU;
      3'b100:  f3_op = ALU_XOR;
      3'b101:  f3_op = funct7_b5 ? ALU_SRA : ALU_SRL;
      3'b110:  f3_op = ALU_OR;
      default: f3_op = ALU_AND;
    endcase
  end

  always_comb begin
    alu_op    = ALU_ADD;
    alu_a     = rs1_val;
    alu_b     = rs2_val;
    pc_sel    = PC_SEQ;
    wb_sel    = WB_ALU;
    writes_rd = 1'b0;
    is_branch = 1'b0;
    unique case (opcode)
      OPC_LUI: begin
        alu_op    = ALU_PASSB;
        alu_b     = imm;
        writes_rd = 1'b1;
      end
      OPC_AUIPC: begin
        alu_a     = pc;
        alu_b     = imm;
        writes_rd = 1'b1;
      end
      OPC_JAL: begin
        pc_sel    = PC_REL;
        wb_sel    = WB_LINK;
        writes_rd = 1'b1;
      end
      OPC_JALR: begin
        pc_sel    = PC_REG;
        wb_sel    = WB_LINK;
        writes_rd = 1'b1;
      end
      OPC_BRANCH: begin
        is_branch = 1'b1;
      end
      OPC_OPIMM: begin
        alu_op    = f3_op;
        alu_b     = imm;
        writes_rd = 1'b1;
      end
      OPC_OP: begin
        alu_op    = f3_op;
        writes_rd = 1'b1;
      end
      default: begin
        writes_rd = 1'b0;
      end
    endcase
  end

  // ---------------- datapath ----------------
  logic [XLEN-1:0] alu_y;
  logic            cmp_hit;
  logic [XLEN-1:0] link_val;
  logic [XLEN-1:0] eff_addr;
  logic [XLEN-1:0] target;
  pc_sel_e         pc_sel_f;

  exu_alu #(.XLEN(XLEN)) u_alu (
    .op (alu_op),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  exu_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .cond (funct3),
    .a    (rs1_val),
    .b    (rs2_val),
    .hit  (cmp_hit)
  );

  assign pc_sel_f = (is_branch && cmp_hit) ? PC_REL : pc_sel;

  exu_pc_unit #(.XLEN(XLEN)) u_pc (
    .sel      (pc_sel_f),
    .pc       (pc),
    .base     (rs1_val),
    .imm      (imm),
    .link     (link_val),
    .eff_addr (eff_addr),
    .target   (target)
  );

  // ---------------- next state ----------------
  logic            wb_en_d;
  logic [XLEN-1:0] wb_data_d;

  always_comb begin
    wb_en_d   = writes_rd && (rd_idx != 5'd0);
    wb_data_d = (wb_sel == WB_LINK) ? link_val : alu_y;
  end

  // ---------------- result register ----------------
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      next_pc   <= '0;
      mem_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        wb_en    <= wb_en_d;
        wb_idx   <= rd_idx;
        wb_data  <= wb_data_d;
        next_pc  <= target;
        mem_addr <= eff_addr;
      end
    end
  end

endmodule

// File: rtl/exu_checker.sv
module exu_checker
  import exu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [6:0]      opcode,
  input logic [2:0]      funct3,
  input logic [4:0]      rd_idx,
  input logic [XLEN-1:0] pc,
  input logic            out_valid,
  input logic            wb_en,
  input logic [4:0]      wb_idx,
  input logic [XLEN-1:0] wb_data,
  input logic [XLEN-1:0] next_pc
);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(wb_data) && $stable(next_pc) && $stable(wb_en)));

  // R10
  x0_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd_idx == 5'd0) |=> !wb_en);

  // R10
  x0_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wb_idx == 5'd0) |-> !wb_en);

  // R6
  branch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OPC_BRANCH || opcode == OPC_STORE)) |=> !wb_en);

  // R4
  jump_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_JALR) |=> (next_pc[0] == 1'b0));

  // R5
  dead_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == OPC_BRANCH && funct3[2:1] == 2'b01)
      |=> (next_pc == $past(pc) + XLEN'(4)));

endmodule

bind int_exec_unit exu_checker #(.XLEN(XLEN)) u_exu_checker (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .funct3    (funct3),
  .rd_idx    (rd_idx),
  .pc        (pc),
  .out_valid (out_valid),
  .wb_en     (wb_en),
  .wb_idx    (wb_idx),
  .wb_data   (wb_data),
  .next_pc   (next_pc)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [6:0]      opcode;
  logic [2:0]      funct3;
  logic            funct7_b5;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rs1_val, rs2_val, pc, imm;
  logic            out_valid, wb_en;
  logic [4:0]      wb_idx;
  logic [XLEN-1:0] wb_data, next_pc, mem_addr;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  int_exec_unit u_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .funct3(funct3), .funct7_b5(funct7_b5), .rd_idx(rd_idx),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc), .imm(imm),
    .out_valid(out_valid), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .next_pc(next_pc), .mem_addr(mem_addr)
  );

  typedef struct packed {
    logic [6:0]  op;
    logic [2:0]  f3;
    logic        f7;
    logic [4:0]  rd;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] vpc;
    logic [31:0] vimm;
    logic        ewen;
    logic [31:0] ewb;
    logic [31:0] enpc;
    logic        ca;
    logic [31:0] eaddr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam logic [6:0] LUI = 7'b0110111, AUI = 7'b0010111, JAL = 7'b1101111,
                         JLR = 7'b1100111, BRA = 7'b1100011, LD  = 7'b0000011,
                         ST  = 7'b0100011, OPI = 7'b0010011, OPR = 7'b0110011;
  localparam logic [31:0] P = 32'h0000_1000;

  localparam vec_t VECS [NV] = '{
    // R3 upper immediate, PC-relative upper immediate
    '{LUI, 3'd0, 1'b0, 5'd5, 32'h0, 32'h0, P, 32'hABCDE000, 1'b1, 32'hABCDE000, 32'h1004, 1'b0, 32'h0, 8'd3},
    '{AUI, 3'd0, 1'b0, 5'd6, 32'h0, 32'h0, P, 32'h00002000, 1'b1, 32'h00003000, 32'h1004, 1'b0, 32'h0, 8'd3},
    // R4 jumps
    '{JAL, 3'd0, 1'b0, 5'd1, 32'h0, 32'h0, P, 32'hFFFFFFF0, 1'b1, 32'h00001004, 32'h0FF0, 1'b0, 32'h0, 8'd4},
    '{JLR, 3'd0, 1'b0, 5'd1, 32'h2001, 32'h0, P, 32'h4, 1'b1, 32'h00001004, 32'h2004, 1'b0, 32'h0, 8'd4},
    // R5 branches
    '{BRA, 3'd0, 1'b0, 5'd0, 32'h7, 32'h7, P, 32'h20, 1'b0, 32'h0, 32'h1020, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd1, 1'b0, 5'd0, 32'h7, 32'h7, P, 32'h20, 1'b0, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd4, 1'b0, 5'd0, 32'hFFFFFFFF, 32'h1, P, 32'h20, 1'b0, 32'h0, 32'h1020, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd6, 1'b0, 5'd0, 32'hFFFFFFFF, 32'h1, P, 32'h20, 1'b0, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd5, 1'b0, 5'd0, 32'h1, 32'hFFFFFFFF, P, 32'h20, 1'b0, 32'h0, 32'h1020, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd7, 1'b0, 5'd0, 32'h1, 32'hFFFFFFFF, P, 32'h20, 1'b0, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd5, 1'b0, 5'd0, 32'h5, 32'h5, P, 32'h20, 1'b0, 32'h0, 32'h1020, 1'b0, 32'h0, 8'd5},
    '{BRA, 3'd2, 1'b0, 5'd0, 32'h0, 32'h0, P, 32'h20, 1'b0, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd5},
    // R7 add/sub, immediate add ignores the select bit
    '{OPR, 3'd0, 1'b0, 5'd3, 32'h7FFFFFFF, 32'h1, P, 32'h0, 1'b1, 32'h80000000, 32'h1004, 1'b0, 32'h0, 8'd7},
    '{OPR, 3'd0, 1'b1, 5'd3, 32'h5, 32'h7, P, 32'h0, 1'b1, 32'hFFFFFFFE, 32'h1004, 1'b0, 32'h0, 8'd7},
    '{OPI, 3'd0, 1'b1, 5'd4, 32'h10, 32'h0, P, 32'hFFFFFFFF, 1'b1, 32'h0000000F, 32'h1004, 1'b0, 32'h0, 8'd7},
    '{OPR, 3'd4, 1'b0, 5'd7, 32'hF0F0, 32'hFF00, P, 32'h0, 1'b1, 32'h00000FF0, 32'h1004, 1'b0, 32'h0, 8'd7},
    '{OPR, 3'd6, 1'b0, 5'd7, 32'hF0F0, 32'hFF00, P, 32'h0, 1'b1, 32'h0000FFF0, 32'h1004, 1'b0, 32'h0, 8'd7},
    '{OPR, 3'd7, 1'b0, 5'd7, 32'hF0F0, 32'hFF00, P, 32'h0, 1'b1, 32'h0000F000, 32'h1004, 1'b0, 32'h0, 8'd7},
    // R8 shifts
    '{OPR, 3'd1, 1'b0, 5'd8, 32'h1, 32'h24, P, 32'h0, 1'b1, 32'h00000010, 32'h1004, 1'b0, 32'h0, 8'd8},
    '{OPR, 3'd5, 1'b1, 5'd8, 32'h80000000, 32'h4, P, 32'h0, 1'b1, 32'hF8000000, 32'h1004, 1'b0, 32'h0, 8'd8},
    '{OPR, 3'd5, 1'b0, 5'd8, 32'h80000000, 32'h4, P, 32'h0, 1'b1, 32'h08000000, 32'h1004, 1'b0, 32'h0, 8'd8},
    '{OPI, 3'd5, 1'b1, 5'd9, 32'hF0000000, 32'h0, P, 32'h402, 1'b1, 32'hFC000000, 32'h1004, 1'b0, 32'h0, 8'd8},
    // R9 set-less-than
    '{OPR, 3'd2, 1'b0, 5'd10, 32'hFFFFFFFE, 32'h1, P, 32'h0, 1'b1, 32'h1, 32'h1004, 1'b0, 32'h0, 8'd9},
    '{OPR, 3'd3, 1'b0, 5'd10, 32'hFFFFFFFE, 32'h1, P, 32'h0, 1'b1, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd9},
    '{OPI, 3'd3, 1'b0, 5'd11, 32'h5, 32'h0, P, 32'hFFFFFFFF, 1'b1, 32'h1, 32'h1004, 1'b0, 32'h0, 8'd9},
    '{OPI, 3'd2, 1'b0, 5'd11, 32'h5, 32'h0, P, 32'hFFFFFFFF, 1'b1, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd9},
    // R6 memory address, no write
    '{ST,  3'd2, 1'b0, 5'd12, 32'h1000, 32'h55, P, 32'hFFFFFFFC, 1'b0, 32'h0, 32'h1004, 1'b1, 32'h00000FFC, 8'd6},
    '{LD,  3'd2, 1'b0, 5'd12, 32'h2000, 32'h0, P, 32'h8, 1'b0, 32'h0, 32'h1004, 1'b1, 32'h00002008, 8'd6},
    // R10 destination zero
    '{OPR, 3'd0, 1'b0, 5'd0, 32'h1, 32'h2, P, 32'h0, 1'b0, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd10},
    // R11 unknown opcode steps on
    '{7'b1111111, 3'd0, 1'b0, 5'd13, 32'h1, 32'h2, P, 32'h0, 1'b0, 32'h0, 32'h1004, 1'b0, 32'h0, 8'd11}
  };

  task automatic chk(input string what, input int req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opcode    = v.op;   funct3  = v.f3;  funct7_b5 = v.f7;
    rd_idx    = v.rd;   rs1_val = v.a;   rs2_val   = v.b;
    pc        = v.vpc;  imm     = v.vimm;
    in_valid  = 1'b1;
  endtask

  logic [31:0] held_wb, held_npc;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; funct3 = '0; funct7_b5 = 1'b0;
    rd_idx = '0; rs1_val = '0; rs2_val = '0; pc = '0; imm = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("out_valid in reset", 1, {31'b0, out_valid}, 32'h0);
    chk("wb_en in reset", 1, {31'b0, wb_en}, 32'h0);
    chk("wb_data in reset", 1, wb_data, 32'h0);
    chk("next_pc in reset", 1, next_pc, 32'h0);
    chk("mem_addr in reset", 1, mem_addr, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("out_valid after release", 1, {31'b0, out_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk("out_valid", 2, {31'b0, out_valid}, 32'h1);
      chk("wb_en", int'(VECS[i].req), {31'b0, wb_en}, {31'b0, VECS[i].ewen});
      if (VECS[i].ewen) begin
        chk("wb_data", int'(VECS[i].req), wb_data, VECS[i].ewb);
        chk("wb_idx", int'(VECS[i].req), {27'b0, wb_idx}, {27'b0, VECS[i].rd});
      end
      chk("next_pc", int'(VECS[i].req), next_pc, VECS[i].enpc);
      if (VECS[i].ca)
        chk("mem_addr", int'(VECS[i].req), mem_addr, VECS[i].eaddr);
    end

    // R2 hold while idle: change inputs, drop valid
    held_wb = wb_data; held_npc = next_pc;
    in_valid = 1'b0; opcode = 7'b0110111; rd_idx = 5'd9; imm = 32'h12345000;
    pc = 32'h8000;
    repeat (2) @(negedge clk);
    chk("out_valid idle", 2, {31'b0, out_valid}, 32'h0);
    chk("wb_data held", 2, wb_data, held_wb);
    chk("next_pc held", 2, next_pc, held_npc);
    chk("wb_en held", 2, {31'b0, wb_en}, 32'h0);

    // R4 jump target with odd sum and negative immediate
    drive('{JLR, 3'd0, 1'b0, 5'd2, 32'h3000, 32'h0, 32'h40, 32'hFFFFFFFF, 1'b1,
            32'h44, 32'h2FFE, 1'b0, 32'h0, 8'd4});
    @(negedge clk);
    chk("jump target bit0 cleared", 4, next_pc, 32'h00002FFE);
    chk("jump link", 4, wb_data, 32'h00000044);

    // R1 reset mid-run clears outputs at once
    in_valid = 1'b0;
    #3 rst_n = 1'b0;
    #2;
    chk("wb_data after mid reset", 1, wb_data, 32'h0);
    chk("next_pc after mid reset", 1, next_pc, 32'h0);
    chk("out_valid after mid reset", 1, {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule